// File: doc/BRIEF.md
# DRAM Write Transaction Sequencer

This block turns write requests into a timed stream of DRAM request packets. Each request names a bank, a row, a starting column and a number of write commands. The block keeps an open-row table with one entry per bank. It uses that table to sort each request into one of three classes: the row is already open (hit), a different row is open (miss), or no row is open (empty). It then issues the command sequence that fits the class: write commands alone, precharge then activate then writes, or activate then writes.

Every gap between commands is enforced by elapsed-cycle counters, compared against timing values that are captured while reset is held. After the last write, a page policy captured at reset decides the next step. Under the close policy the bank is precharged. Under the open policy the row stays open for later hits. Write data is signalled on a separate strobe that rises a programmable number of cycles after each write command and stays high for one packet length.

Top module: `dram_wr_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, wd_valid is 0, and every bank is treated as closed.
- R2: A request to a closed bank issues an activate (cmd_op 1) carrying the row. Its first write (cmd_op 3) follows no earlier than cfg_trcd cycles after the activate.
- R3: A request to a bank whose open row equals the requested row issues only write commands, with no activate or precharge.
- R4: A request to a bank that has a different row open issues a precharge (cmd_op 2), then an activate. The activate comes no earlier than cfg_trp cycles after the precharge, and the writes follow.
- R5: Successive write commands are at least cfg_tcc cycles apart. Their columns are the request column, then that column plus 1, and so on.
- R6: For each write command issued in cycle w, wd_valid is high in cycles w+cfg_tcwd through w+cfg_tcwd+cfg_tcc-1.
- R7: Under the close policy (cfg_close=1), a precharge follows the last write. It comes no sooner than cfg_twrp cycles after that write and no sooner than cfg_tras cycles after the last activate.
- R8: Under the open policy (cfg_close=0), no precharge follows the writes, and the row stays recorded as open.
- R9: req_ready is low from the cycle after a request is accepted until the transaction ends. Requests presented in that window are ignored.
- R10: Configuration inputs are captured only while rst_n is low. Changing them afterwards has no effect.
- R11: A write count of 0 is treated as a single write.
- R12: Each command is issued in the first cycle that all of its timing constraints allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_trp | input | 8 | Precharge-to-activate cycles |
| cfg_trcd | input | 8 | Activate-to-first-write cycles |
| cfg_tcc | input | 8 | Write-to-write cycles and data packet length |
| cfg_tcwd | input | 4 | Write command to data strobe delay |
| cfg_twrp | input | 8 | Last write to precharge cycles |
| cfg_tras | input | 8 | Activate to precharge cycles |
| cfg_close | input | 1 | Page policy: 1 closes the bank after the writes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_bank | input | 3 | Target bank |
| req_row | input | 14 | Target row |
| req_col | input | 7 | First column |
| req_count | input | 4 | Number of writes (0 means 1) |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 2 | 1 activate, 2 precharge, 3 write |
| cmd_bank | output | 3 | Command bank |
| cmd_row | output | 14 | Row for an activate, else 0 |
| cmd_col | output | 7 | Column for a write, else 0 |
| wd_valid | output | 1 | Write data packet strobe |

## Verification
The case that is hardest to reach from the ports is a page miss. It needs a row that was left open by an earlier transaction. Under the close policy, a row is never left open. The bench therefore resets a second time with the open policy. It opens a row, hits it, and then requests a different row in the same bank. Separately, write counts are chosen so that the activate-to-precharge bound decides the closing precharge in one transaction and the write-to-precharge bound decides it in another.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_PRE = 2'd2,
    OP_WR  = 2'd3
  } wseq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEED_PRE,
    ST_NEED_ACT,
    ST_WRITES,
    ST_CLOSE
  } wseq_st_e;

  typedef enum logic [1:0] {
    PG_HIT,
    PG_MISS,
    PG_EMPTY
  } wseq_pg_e;
endpackage

// File: rtl/wseq_since.sv
module wseq_since #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  output logic [TW-1:0] since
);
  // cycles elapsed since the last fire, saturating; saturated means unconstrained
  always_ff @(posedge clk) begin
    if (!rst_n)            since <= '1;
    else if (fire)         since <= TW'(1);
    else if (since != '1)  since <= since + 1'b1;
  end
endmodule

// File: rtl/wseq_rowtab.sv
module wseq_rowtab
  import wseq_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int ROWW  = 14,
  localparam int BANKW = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BANKW-1:0] lk_bank,
  input  logic [ROWW-1:0]  lk_row,
  output wseq_pg_e         lk_class,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic [BANKW-1:0] upd_bank,
  input  logic [ROWW-1:0]  upd_row
);
  logic [NBANK-1:0] vld;
  logic [ROWW-1:0]  rows [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[b]  <= 1'b0;
        rows[b] <= '0;
      end else if (act_fire && upd_bank == BANKW'(b)) begin
        vld[b]  <= 1'b1;
        rows[b] <= upd_row;
      end else if (pre_fire && upd_bank == BANKW'(b)) begin
        vld[b]  <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!vld[lk_bank])                lk_class = PG_EMPTY;
    else if (rows[lk_bank] == lk_row) lk_class = PG_HIT;
    else                              lk_class = PG_MISS;
  end

  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> !vld[upd_bank]);  // R4
  AST_PRE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |-> vld[upd_bank]);  // R7
endmodule

// File: rtl/wseq_wdata.sv
module wseq_wdata #(
  parameter int TW      = 8,
  parameter int MAX_CWD = 15,
  localparam int CWDW   = $clog2(MAX_CWD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic [CWDW-1:0] cwd,
  input  logic [TW-1:0]   tcc,
  output logic            wd_valid
);
  logic [MAX_CWD:1] hist;
  logic [TW-1:0]    cnt;
  logic             launch;

  assign launch   = (cwd == '0) ? wr_fire : hist[cwd];
  assign wd_valid = launch || (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
    end else begin
      hist <= {hist[MAX_CWD-1:1], wr_fire};
      if (launch)          cnt <= (tcc == '0) ? '0 : tcc - 1'b1;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  AST_WD_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> cnt == '0);  // R5
endmodule

// File: rtl/dram_wr_seq.sv
module dram_wr_seq
  import wseq_pkg::*;
#(
  parameter int NBANK   = 8,
  parameter int ROWW    = 14,
  parameter int COLW    = 7,
  parameter int CNTW    = 4,
  parameter int TW      = 8,
  parameter int MAX_CWD = 15,
  localparam int BANKW  = $clog2(NBANK),
  localparam int CWDW   = $clog2(MAX_CWD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_tcc,
  input  logic [CWDW-1:0]  cfg_tcwd,
  input  logic [TW-1:0]    cfg_twrp,
  input  logic [TW-1:0]    cfg_tras,
  input  logic             cfg_close,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BANKW-1:0] req_bank,
  input  logic [ROWW-1:0]  req_row,
  input  logic [COLW-1:0]  req_col,
  input  logic [CNTW-1:0]  req_count,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [BANKW-1:0] cmd_bank,
  output logic [ROWW-1:0]  cmd_row,
  output logic [COLW-1:0]  cmd_col,
  output logic             wd_valid
);
  function automatic logic elapsed(input logic [TW-1:0] s, input logic [TW-1:0] lim);
    return s >= lim;
  endfunction

  function automatic logic [CNTW-1:0] wr_total(input logic [CNTW-1:0] c);
    return (c == '0) ? CNTW'(1) : c;
  endfunction

  // configuration captured while reset is held
  logic [TW-1:0]   t_rp, t_rcd, t_cc, t_wrp, t_ras;
  logic [CWDW-1:0] t_cwd;
  logic            close_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_rp    <= cfg_trp;
      t_rcd   <= cfg_trcd;
      t_cc    <= cfg_tcc;
      t_cwd   <= cfg_tcwd;
      t_wrp   <= cfg_twrp;
      t_ras   <= cfg_tras;
      close_q <= cfg_close;
    end
  end

  wseq_st_e         st;
  logic [BANKW-1:0] cur_bank;
  logic [ROWW-1:0]  cur_row;
  logic [COLW-1:0]  cur_col;
  logic [CNTW-1:0]  rem_q;

  // named internal events
  logic             accept, act_fire, pre_fire, wr_fire;
  logic             ok_pre, ok_act, ok_wr;
  logic [TW-1:0]    s_act, s_pre, s_wr;
  wseq_pg_e         lk_class;
  logic [BANKW-1:0] lk_bank;
  logic [ROWW-1:0]  lk_row;
  wseq_op_e         op;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lk_bank   = (st == ST_IDLE) ? req_bank : cur_bank;
  assign lk_row    = (st == ST_IDLE) ? req_row  : cur_row;

  assign ok_pre = elapsed(s_act, t_ras) && elapsed(s_wr, t_wrp);
  assign ok_act = elapsed(s_pre, t_rp);
  assign ok_wr  = elapsed(s_act, t_rcd) && elapsed(s_wr, t_cc);

  assign pre_fire = ((st == ST_NEED_PRE) || (st == ST_CLOSE)) && ok_pre;
  assign act_fire = (st == ST_NEED_ACT) && ok_act;
  assign wr_fire  = (st == ST_WRITES) && ok_wr;

  always_comb begin
    op = OP_NOP;
    if (pre_fire)      op = OP_PRE;
    else if (act_fire) op = OP_ACT;
    else if (wr_fire)  op = OP_WR;
  end

  assign cmd_valid = (op != OP_NOP);
  assign cmd_op    = op;
  assign cmd_bank  = cur_bank;
  assign cmd_row   = act_fire ? cur_row : '0;
  assign cmd_col   = wr_fire  ? cur_col : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_bank <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      rem_q    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cur_bank <= req_bank;
          cur_row  <= req_row;
          cur_col  <= req_col;
          rem_q    <= wr_total(req_count);
          unique case (lk_class)
            PG_HIT:  st <= ST_WRITES;
            PG_MISS: st <= ST_NEED_PRE;
            default: st <= ST_NEED_ACT;
          endcase
        end
        ST_NEED_PRE: if (pre_fire) st <= ST_NEED_ACT;
        ST_NEED_ACT: if (act_fire) st <= ST_WRITES;
        ST_WRITES: if (wr_fire) begin
          cur_col <= cur_col + 1'b1;
          rem_q   <= rem_q - 1'b1;
          if (rem_q == CNTW'(1)) st <= close_q ? ST_CLOSE : ST_IDLE;
        end
        ST_CLOSE: if (pre_fire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  wseq_since #(.TW(TW)) u_since_act (.clk(clk), .rst_n(rst_n), .fire(act_fire), .since(s_act));
  wseq_since #(.TW(TW)) u_since_pre (.clk(clk), .rst_n(rst_n), .fire(pre_fire), .since(s_pre));
  wseq_since #(.TW(TW)) u_since_wr  (.clk(clk), .rst_n(rst_n), .fire(wr_fire),  .since(s_wr));

  wseq_rowtab #(.NBANK(NBANK), .ROWW(ROWW)) u_rowtab (
    .clk(clk), .rst_n(rst_n), .lk_bank(lk_bank), .lk_row(lk_row), .lk_class(lk_class),
    .act_fire(act_fire), .pre_fire(pre_fire), .upd_bank(cur_bank), .upd_row(cur_row)
  );

  wseq_wdata #(.TW(TW), .MAX_CWD(MAX_CWD)) u_wdata (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .cwd(t_cwd), .tcc(t_cc), .wd_valid(wd_valid)
  );

  AST_WR_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> lk_class == PG_HIT);  // R3
  AST_ACCEPT_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !cmd_valid);  // R9
  AST_OPEN_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rem_q == CNTW'(1) && !close_q) |=> req_ready);  // R8
  AST_CLOSE_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLOSE && pre_fire) |=> (req_ready && !cmd_valid));  // R7
endmodule

// File: tb/dram_wr_seq_bench.sv
`timescale 1ns/1ps
module dram_wr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_trp, cfg_trcd, cfg_tcc, cfg_twrp, cfg_tras;
  logic [3:0]  cfg_tcwd;
  logic        cfg_close;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [6:0]  req_col = '0;
  logic [3:0]  req_count = '0;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic [6:0]  cmd_col;
  logic        wd_valid;

  always #10 clk = ~clk;

  dram_wr_seq u_dram_wr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_tcc(cfg_tcc),
    .cfg_tcwd(cfg_tcwd), .cfg_twrp(cfg_twrp), .cfg_tras(cfg_tras), .cfg_close(cfg_close),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_count(req_count), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .wd_valid(wd_valid)
  );

  int cyc = 0;
  int total = 0;
  int fails = 0;
  int log_op [8192];
  int log_bank [8192];
  int log_val [8192];
  bit wd_log [8192];

  // bench-side copy of configuration and open-row model
  int Trp, Trcd, Tcc, Tcwd, Twrp, Tras;
  bit Close;
  int last_act, last_pre, last_wr;
  bit bopen [8];
  int brow [8];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cyc < 8192) begin
      log_op[cyc]   = cmd_valid ? int'(cmd_op) : 0;
      log_bank[cyc] = int'(cmd_bank);
      log_val[cyc]  = (cmd_op == 2'd1) ? int'(cmd_row) : int'(cmd_col);
      wd_log[cyc]   = wd_valid;
    end
  end

  always @(posedge clk) begin
    if (cyc > 30000) begin
      total++;
      fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 30000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int rp, rcd, cc, cwd, wrp, ras, input bit cl);
    Trp = rp; Trcd = rcd; Tcc = cc; Tcwd = cwd; Twrp = wrp; Tras = ras; Close = cl;
    cfg_trp = 8'(rp); cfg_trcd = 8'(rcd); cfg_tcc = 8'(cc); cfg_tcwd = 4'(cwd);
    cfg_twrp = 8'(wrp); cfg_tras = 8'(ras); cfg_close = cl;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_act = -1000; last_pre = -1000; last_wr = -1000;
    for (int b = 0; b < 8; b++) begin bopen[b] = 1'b0; brow[b] = 0; end
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1", "no command after reset", int'(cmd_valid), 0);
    chk(wd_valid == 1'b0, "R1", "no data strobe after reset", int'(wd_valid), 0);
  endtask

  task automatic expect_cmd(input int c, input int op, input int bank, input int val, input string req);
    chk(log_op[c] == op, req, $sformatf("op at cycle %0d", c), log_op[c], op);
    chk(log_bank[c] == bank && log_val[c] == val, req, $sformatf("bank*65536+arg at cycle %0d", c),
        log_bank[c] * 65536 + log_val[c], bank * 65536 + val);
  endtask

  task automatic run_txn(input int bank, input int row, input int col, input int cnt,
                         input bit poke, input string tag_cnt);
    int a, pre, act, n, ncmd, seen, wds;
    int wr [16];
    bit hit, miss;
    string cls_req;
    hit  = bopen[bank] && brow[bank] == row;
    miss = bopen[bank] && brow[bank] != row;
    n = (cnt == 0) ? 1 : cnt;
    while (!req_ready) @(negedge clk);
    req_bank = 3'(bank); req_row = 14'(row); req_col = 7'(col); req_count = 4'(cnt);
    req_valid = 1'b1;
    @(negedge clk);
    a = cyc;
    req_valid = 1'b0;
    if (poke) begin
      // R9: a second request held while busy must be refused and leave no trace
      req_bank = 3'd5; req_row = 14'h155; req_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        chk(req_ready == 1'b0, "R9", "ready low while busy", int'(req_ready), 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (!req_ready) @(negedge clk);
    repeat (Tcwd + Tcc + 4) @(negedge clk);

    ncmd = 0;
    act = -1;
    cls_req = hit ? "R3" : (miss ? "R4" : "R2");
    if (miss) begin
      pre = mx(a, mx(last_act + Tras, last_wr + Twrp));
      expect_cmd(pre, 2, bank, 0, "R12");
      last_pre = pre;
      act = mx(pre + 1, pre + Trp);
      ncmd++;
    end else if (!hit) begin
      act = mx(a, last_pre + Trp);
    end
    if (act >= 0) begin
      expect_cmd(act, 1, bank, row, cls_req);
      last_act = act;
      ncmd++;
    end
    if (hit) wr[0] = mx(a, mx(last_act + Trcd, last_wr + Tcc));
    else     wr[0] = mx(act + 1, mx(act + Trcd, last_wr + Tcc));
    for (int i = 0; i < n; i++) begin
      if (i > 0) wr[i] = wr[i-1] + Tcc;
      expect_cmd(wr[i], 3, bank, (col + i) % 128, "R5");
      ncmd++;
    end
    last_wr = wr[n-1];
    if (Close) begin
      pre = mx(last_wr + 1, mx(last_wr + Twrp, last_act + Tras));
      expect_cmd(pre, 2, bank, 0, "R7");
      last_pre = pre;
      ncmd++;
      bopen[bank] = 1'b0;
    end else begin
      bopen[bank] = 1'b1;
      brow[bank] = row;
    end
    seen = 0;
    wds = 0;
    for (int c = a; c <= cyc; c++) begin
      if (log_op[c] != 0) seen++;
      if (wd_log[c]) wds++;
    end
    chk(seen == ncmd, tag_cnt, "command count in transaction", seen, ncmd);
    for (int i = 0; i < n; i++) begin
      int hi = 0;
      for (int k = 0; k < Tcc; k++) if (wd_log[wr[i] + Tcwd + k]) hi++;
      chk(hi == Tcc, "R6", $sformatf("strobe cycles after write %0d", i), hi, Tcc);
    end
    chk(wds == n * Tcc, "R6", "total strobe cycles", wds, n * Tcc);
  endtask

  task automatic scen_empty_close();   run_txn(1, 16, 8, 2, 1'b0, "R2");  endtask
  task automatic scen_reclosed();      run_txn(1, 16, 20, 2, 1'b0, "R7"); endtask
  task automatic scen_wrp_bound();     run_txn(2, 300, 100, 4, 1'b0, "R7"); endtask
  task automatic scen_count_zero();    run_txn(4, 7, 127, 0, 1'b0, "R11"); endtask
  task automatic scen_open_keep();     run_txn(3, 32, 0, 2, 1'b0, "R8");  endtask
  task automatic scen_hit();           run_txn(3, 32, 64, 3, 1'b0, "R3"); endtask
  task automatic scen_miss();          run_txn(3, 33, 10, 1, 1'b0, "R4"); endtask
  task automatic scen_busy();          run_txn(3, 33, 11, 3, 1'b1, "R9"); endtask
  task automatic scen_cfg_frozen();
    cfg_trp = 8'd40; cfg_trcd = 8'd40; cfg_tcc = 8'd9; cfg_tcwd = 4'd11;
    cfg_twrp = 8'd50; cfg_tras = 8'd60; cfg_close = 1'b1;
    run_txn(3, 33, 30, 2, 1'b0, "R10");
  endtask

  initial begin
    cfg_trp = '0; cfg_trcd = '0; cfg_tcc = '0; cfg_tcwd = '0;
    cfg_twrp = '0; cfg_tras = '0; cfg_close = 1'b0;
    do_reset(3, 4, 2, 5, 6, 14, 1'b1);
    scen_empty_close();
    scen_reclosed();
    scen_wrp_bound();
    scen_count_zero();
    do_reset(2, 3, 3, 2, 4, 9, 1'b0);
    scen_open_keep();
    scen_hit();
    scen_miss();
    scen_busy();
    scen_cfg_frozen();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule